// File: doc/BRIEF.md
# Packet Header Classifier Demultiplexer

This block sits on a 64-bit AXI-Stream link that carries framed packets. The first beat of every packet is a compact routing header. The block decodes a three-bit packet class from that beat and steers the whole packet, up to and including the beat with tlast, to one of four AXI-Stream outputs:

- sample data,
- flow control,
- command,
- response.

Packets whose class code is unassigned are read in full and discarded. They are counted, and they set a sticky error flag.

While a packet is routed, the header fields are captured into registers and presented as sideband outputs for downstream logic. These fields are the sequence number, the byte length, the source and destination stream IDs, and the timestamp-present flag. The destination stream ID is also split into its sub-fields.

Each output owns a one-entry register stage, so every output port is driven from a flop. The input accepts a beat only when the output chosen for the packet can take it. Backpressure on one output therefore stalls the input only while a packet bound for that output is in flight.

Top module: `pkt_hdr_demux`

## Requirements
- R1: The class code is {hdr[63], hdr[62], hdr[60]} of the first beat. Codes are routed to outputs as follows:
  - 000 and 001 go to output 0 (data).
  - 010 goes to output 1 (flow control).
  - 100 goes to output 2 (command).
  - 110 and 111 go to output 3 (response).
  - Output k uses bits [64k+63:64k] of out_tdata.
- R2: After a header is accepted, every later beat of that packet goes to the same output, whatever its contents, until the beat with tlast is accepted. Only then is a new header decoded.
- R3: When hdr[61] is set, the beat after the header is a timestamp word. It is forwarded unchanged on the same output as part of the packet.
- R4: On acceptance of a header, the sideband outputs are loaded and then held until the next header is accepted:
  - hdr_seq = hdr[59:48]
  - hdr_len = hdr[47:32]
  - hdr_src_sid = hdr[31:16]
  - hdr_dst_sid = hdr[15:0]
  - hdr_has_time = hdr[61]
- R5: The destination ID is split as follows: dst_xbar_id = hdr[15:8], dst_xbar_port = hdr[7:4], dst_blk_port = hdr[3:0].
- R6: out_tuser carries a per-beat flag held on every beat of a packet:
  - On output 0 it is 1 for code 001 (end of burst).
  - On output 3 it is 1 for code 111 (error response).
  - In every other case it is 0.
- R7: Packets with code 011 or 101 are consumed in full, with in_tready high for every beat, and produce no beat on any output.
- R8: Each discarded packet sets bad_type_seen, which stays set until reset. Each discarded packet also adds exactly one to drop_count, which saturates at 2^CNT_W-1.
- R9: in_tready is low whenever no packet is in progress and in_tvalid is low. While a packet is routed to an output whose register stage is full and whose tready is low, in_tready is low. Beats are never lost or reordered under backpressure.
- R10: Once an output raises tvalid, tvalid, tdata, tlast and tuser stay unchanged until tready is seen high.
- R11: After reset, all out_tvalid bits are 0, in_tready is 0, bad_type_seen is 0 and drop_count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_tdata | input | 64 | Input stream data |
| in_tlast | input | 1 | Input end of packet |
| in_tvalid | input | 1 | Input beat valid |
| in_tready | output | 1 | Input beat accepted |
| out_tdata | output | 256 | Four 64-bit output data buses, output k in bits [64k+63:64k] |
| out_tlast | output | 4 | Per-output end of packet |
| out_tuser | output | 4 | Per-output flag (end of burst on 0, error on 3) |
| out_tvalid | output | 4 | Per-output beat valid |
| out_tready | input | 4 | Per-output downstream ready |
| hdr_has_time | output | 1 | Timestamp-present flag of the last header |
| hdr_seq | output | 12 | Sequence number of the last header |
| hdr_len | output | 16 | Byte length of the last header |
| hdr_src_sid | output | 16 | Source stream ID of the last header |
| hdr_dst_sid | output | 16 | Destination stream ID of the last header |
| dst_xbar_id | output | 8 | Destination crossbar/device ID |
| dst_xbar_port | output | 4 | Destination crossbar port |
| dst_blk_port | output | 4 | Destination block port |
| bad_type_seen | output | 1 | Sticky flag for a discarded packet |
| drop_count | output | CNT_W | Saturating count of discarded packets |

## Verification
The bench sweeps all eight class codes against timestamp presence and several packet lengths, under both full-rate and pseudo-random per-output backpressure. The payload beats are built to look like headers of a different class. This exposes a design that re-decodes mid-packet, because it would scatter a packet's body across outputs.

A narrow drop counter is driven well past its limit. A non-saturating counter would wrap back to zero, and a counter that counts beats would overshoot the expected value.

A stalled output is held with a full stage while a body beat waits at the input. A design that let in_tready follow another output, or that overwrote its stage, would lose or corrupt that beat or the held header word.

// File: rtl/pkt_hdr_pkg.sv
package pkt_hdr_pkg;

  localparam int unsigned PKT_W     = 64;
  localparam int unsigned NUM_OUT   = 4;
  localparam int unsigned SEQ_W     = 12;
  localparam int unsigned LEN_W     = 16;
  localparam int unsigned SID_W     = 16;

  // header bit positions
  localparam int unsigned B_CLS_HI  = 63;
  localparam int unsigned B_CLS_MID = 62;
  localparam int unsigned B_TIME    = 61;
  localparam int unsigned B_CLS_LO  = 60;
  localparam int unsigned SEQ_LSB   = 48;
  localparam int unsigned LEN_LSB   = 32;
  localparam int unsigned SRC_LSB   = 16;
  localparam int unsigned DST_LSB   = 0;

  typedef enum logic [2:0] {
    RT_DATA = 3'd0,
    RT_FLOW = 3'd1,
    RT_CMD  = 3'd2,
    RT_RESP = 3'd3,
    RT_DROP = 3'd4
  } route_e;

  typedef struct packed {
    route_e             route;
    logic               flag;
    logic               has_time;
    logic [SEQ_W-1:0]   seq;
    logic [LEN_W-1:0]   len;
    logic [SID_W-1:0]   src;
    logic [SID_W-1:0]   dst;
  } hdr_info_t;

endpackage

// File: rtl/phd_decode.sv
module phd_decode
  import pkt_hdr_pkg::*;
(
  input  logic [PKT_W-1:0] beat,
  output hdr_info_t        info
);

  logic [2:0] cls;

  always_comb begin
    cls = {beat[B_CLS_HI], beat[B_CLS_MID], beat[B_CLS_LO]};
    info.has_time = beat[B_TIME];
    info.seq      = beat[SEQ_LSB +: SEQ_W];
    info.len      = beat[LEN_LSB +: LEN_W];
    info.src      = beat[SRC_LSB +: SID_W];
    info.dst      = beat[DST_LSB +: SID_W];
    info.flag     = 1'b0;
    case (cls)
      3'b000: info.route = RT_DATA;
      3'b001: begin info.route = RT_DATA; info.flag = 1'b1; end
      3'b010: info.route = RT_FLOW;
      3'b100: info.route = RT_CMD;
      3'b110: info.route = RT_RESP;
      3'b111: begin info.route = RT_RESP; info.flag = 1'b1; end
      default: info.route = RT_DROP;
    endcase
  end

endmodule

// File: rtl/phd_route_lock.sv
module phd_route_lock
  import pkt_hdr_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   in_valid,
  input  logic   in_last,
  input  logic   fire,
  input  route_e dec_route,
  input  logic   dec_flag,
  output route_e sel_route,
  output logic   sel_flag,
  output logic   active,
  output logic   is_hdr
);

  logic   locked;
  route_e route_q;
  logic   flag_q;

  assign is_hdr    = !locked;
  assign active    = locked || in_valid;
  assign sel_route = locked ? route_q : dec_route;
  assign sel_flag  = locked ? flag_q  : dec_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked  <= 1'b0;
      route_q <= RT_DROP;
      flag_q  <= 1'b0;
    end else if (fire) begin
      if (in_last) begin
        locked <= 1'b0;
      end else if (!locked) begin
        locked  <= 1'b1;
        route_q <= dec_route;
        flag_q  <= dec_flag;
      end
    end
  end

endmodule

// File: rtl/phd_out_stage.sv
module phd_out_stage #(
  parameter int unsigned DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] d_in,
  input  logic          last_in,
  input  logic          flag_in,
  output logic          space,
  output logic [DW-1:0] d_out,
  output logic          last_out,
  output logic          flag_out,
  output logic          valid,
  input  logic          ready
);

  assign space = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      d_out    <= d_in;
      last_out <= last_in;
      flag_out <= flag_in;
    end
  end

endmodule

// File: rtl/pkt_hdr_demux.sv
module pkt_hdr_demux
  import pkt_hdr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PKT_W-1:0]         in_tdata,
  input  logic                     in_tlast,
  input  logic                     in_tvalid,
  output logic                     in_tready,
  output logic [NUM_OUT*PKT_W-1:0] out_tdata,
  output logic [NUM_OUT-1:0]       out_tlast,
  output logic [NUM_OUT-1:0]       out_tuser,
  output logic [NUM_OUT-1:0]       out_tvalid,
  input  logic [NUM_OUT-1:0]       out_tready,
  output logic                     hdr_has_time,
  output logic [SEQ_W-1:0]         hdr_seq,
  output logic [LEN_W-1:0]         hdr_len,
  output logic [SID_W-1:0]         hdr_src_sid,
  output logic [SID_W-1:0]         hdr_dst_sid,
  output logic [7:0]               dst_xbar_id,
  output logic [3:0]               dst_xbar_port,
  output logic [3:0]               dst_blk_port,
  output logic                     bad_type_seen,
  output logic [CNT_W-1:0]         drop_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  hdr_info_t          dec;
  route_e             sel_route;
  logic               sel_flag;
  logic               active;
  logic               is_hdr;
  logic               fire;
  logic [NUM_OUT-1:0] space;
  logic               route_ok;

  phd_decode dec_i (
    .beat (in_tdata),
    .info (dec)
  );

  phd_route_lock lock_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_tvalid),
    .in_last   (in_tlast),
    .fire      (fire),
    .dec_route (dec.route),
    .dec_flag  (dec.flag),
    .sel_route (sel_route),
    .sel_flag  (sel_flag),
    .active    (active),
    .is_hdr    (is_hdr)
  );

  assign route_ok  = (sel_route == RT_DROP) ? 1'b1 : space[sel_route[1:0]];
  assign in_tready = active && route_ok;
  assign fire      = in_tvalid && in_tready;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    logic load;
    assign load = fire && (sel_route != RT_DROP) && (sel_route[1:0] == 2'(i));

    phd_out_stage #(.DW(PKT_W)) stage_i (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .d_in     (in_tdata),
      .last_in  (in_tlast),
      .flag_in  (sel_flag),
      .space    (space[i]),
      .d_out    (out_tdata[i*PKT_W +: PKT_W]),
      .last_out (out_tlast[i]),
      .flag_out (out_tuser[i]),
      .valid    (out_tvalid[i]),
      .ready    (out_tready[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_has_time <= 1'b0;
      hdr_seq      <= '0;
      hdr_len      <= '0;
      hdr_src_sid  <= '0;
      hdr_dst_sid  <= '0;
    end else if (fire && is_hdr) begin
      hdr_has_time <= dec.has_time;
      hdr_seq      <= dec.seq;
      hdr_len      <= dec.len;
      hdr_src_sid  <= dec.src;
      hdr_dst_sid  <= dec.dst;
    end
  end

  assign dst_xbar_id   = hdr_dst_sid[15:8];
  assign dst_xbar_port = hdr_dst_sid[7:4];
  assign dst_blk_port  = hdr_dst_sid[3:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      bad_type_seen <= 1'b0;
      drop_count    <= '0;
    end else if (fire && is_hdr && (dec.route == RT_DROP)) begin
      bad_type_seen <= 1'b1;
      if (drop_count != CNT_MAX) drop_count <= drop_count + 1'b1;
    end
  end

endmodule

// File: rtl/pkt_hdr_demux_chk.sv
module pkt_hdr_demux_chk
  import pkt_hdr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_OUT*PKT_W-1:0] out_tdata,
  input logic [NUM_OUT-1:0]       out_tlast,
  input logic [NUM_OUT-1:0]       out_tuser,
  input logic [NUM_OUT-1:0]       out_tvalid,
  input logic [NUM_OUT-1:0]       out_tready,
  input logic                     bad_type_seen,
  input logic [CNT_W-1:0]         drop_count
);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_port
    // R10
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (out_tvalid[i] && !out_tready[i]) |=> out_tvalid[i]);
    // R10
    payload_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (out_tvalid[i] && !out_tready[i]) |=>
        ($stable(out_tdata[i*PKT_W +: PKT_W]) && $stable(out_tlast[i]) && $stable(out_tuser[i])));
  end

  // R6
  flag_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (out_tvalid[1] || out_tvalid[2]) |-> !(out_tuser[1] && out_tvalid[1]) && !(out_tuser[2] && out_tvalid[2]));
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    bad_type_seen |=> bad_type_seen);
  // R8
  cnt_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (drop_count >= $past(drop_count)));
  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((drop_count - $past(drop_count)) <= CNT_W'(1)));
  // R8
  cnt_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (drop_count != '0) |-> bad_type_seen);

endmodule

bind pkt_hdr_demux pkt_hdr_demux_chk #(.CNT_W(CNT_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .out_tdata     (out_tdata),
  .out_tlast     (out_tlast),
  .out_tuser     (out_tuser),
  .out_tvalid    (out_tvalid),
  .out_tready    (out_tready),
  .bad_type_seen (bad_type_seen),
  .drop_count    (drop_count)
);

// File: tb/pkt_hdr_demux_tb_top.sv
module pkt_hdr_demux_tb_top;
  import pkt_hdr_pkg::*;

  localparam int unsigned TB_CNT_W = 2;
  localparam int unsigned CNT_SAT  = (1 << TB_CNT_W) - 1;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic [63:0]              in_tdata = '0;
  logic                     in_tlast = 1'b0;
  logic                     in_tvalid = 1'b0;
  logic                     in_tready;
  logic [255:0]             out_tdata;
  logic [3:0]               out_tlast, out_tuser, out_tvalid;
  logic [3:0]               out_tready = 4'h0;
  logic                     hdr_has_time;
  logic [11:0]              hdr_seq;
  logic [15:0]              hdr_len, hdr_src_sid, hdr_dst_sid;
  logic [7:0]               dst_xbar_id;
  logic [3:0]               dst_xbar_port, dst_blk_port;
  logic                     bad_type_seen;
  logic [TB_CNT_W-1:0]      drop_count;

  int unsigned tests = 0;
  int unsigned fails = 0;
  int unsigned rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [65:0] exp_q [4][$];
  int unsigned drop_exp = 0;

  always #10 clk = ~clk;

  pkt_hdr_demux #(.CNT_W(TB_CNT_W)) dut_i (
    .clk(clk), .rst(rst),
    .in_tdata(in_tdata), .in_tlast(in_tlast), .in_tvalid(in_tvalid), .in_tready(in_tready),
    .out_tdata(out_tdata), .out_tlast(out_tlast), .out_tuser(out_tuser),
    .out_tvalid(out_tvalid), .out_tready(out_tready),
    .hdr_has_time(hdr_has_time), .hdr_seq(hdr_seq), .hdr_len(hdr_len),
    .hdr_src_sid(hdr_src_sid), .hdr_dst_sid(hdr_dst_sid),
    .dst_xbar_id(dst_xbar_id), .dst_xbar_port(dst_xbar_port), .dst_blk_port(dst_blk_port),
    .bad_type_seen(bad_type_seen), .drop_count(drop_count)
  );

  task automatic check(input bit ok, input string req, input logic [65:0] act, input logic [65:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_hdr(input logic [2:0] c, input logic ht, input logic [11:0] seq,
                                         input logic [15:0] len, input logic [15:0] src, input logic [15:0] dst);
    logic [63:0] h;
    h = {4'b0, seq, len, src, dst};
    h[63] = c[2]; h[62] = c[1]; h[61] = ht; h[60] = c[0];
    return h;
  endfunction

  function automatic int exp_route(input logic [2:0] c);
    case (c)
      3'd0, 3'd1: return 0;
      3'd2:       return 1;
      3'd4:       return 2;
      3'd6, 3'd7: return 3;
      default:    return 4;
    endcase
  endfunction

  // ready driver
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      0: out_tready = 4'hF;
      1: out_tready = lfsr[3:0] | lfsr[7:4];
      default: out_tready = 4'h0;
    endcase
  end

  // output monitor (R1 R2 R3 R6 R7 R9)
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < 4; i++) begin
        if (out_tvalid[i] && out_tready[i]) begin
          logic [65:0] got;
          got = {out_tuser[i], out_tlast[i], out_tdata[i*64 +: 64]};
          if (exp_q[i].size() == 0) begin
            check(1'b0, "R1/R7 unexpected beat", got, '0);
          end else begin
            logic [65:0] e;
            e = exp_q[i].pop_front();
            check(got == e, "R1/R2/R3/R6/R9 beat", got, e);
          end
        end
      end
    end
  end

  task automatic send_beat(input logic [63:0] d, input logic last, input int rt, input logic flag);
    in_tdata = d; in_tlast = last; in_tvalid = 1'b1;
    do @(negedge clk); while (!in_tready);
    if (rt < 4) exp_q[rt].push_back({flag, last, d});
    @(posedge clk); #1;
    in_tvalid = 1'b0;
  endtask

  task automatic send_pkt(input logic [2:0] c, input logic ht, input int nbody, input int n);
    logic [63:0] h;
    int rt;
    logic fl;
    int total;
    logic [15:0] src, dst;
    total = 1 + (ht ? 1 : 0) + nbody;
    src = {8'(n), 4'(n + 1), 4'(n + 2)};
    dst = {8'(n * 3), 4'(n), 4'(~n)};
    h = mk_hdr(c, ht, 12'(n), 16'(total * 8), src, dst);
    rt = exp_route(c);
    fl = (c == 3'd1) || (c == 3'd7);
    send_beat(h, total == 1, rt, fl);
    // R4 R5 sideband after header accepted
    check({hdr_has_time, hdr_seq, hdr_len, hdr_src_sid, hdr_dst_sid} ==
          {ht, 12'(n), 16'(total * 8), src, dst}, "R4 header fields",
          66'({hdr_has_time, hdr_seq, hdr_len, hdr_src_sid, hdr_dst_sid}),
          66'({ht, 12'(n), 16'(total * 8), src, dst}));
    check({dst_xbar_id, dst_xbar_port, dst_blk_port} == {dst[15:8], dst[7:4], dst[3:0]},
          "R5 dst split", 66'({dst_xbar_id, dst_xbar_port, dst_blk_port}), 66'(dst));
    if (rt == 4 && drop_exp < CNT_SAT) drop_exp++;
    if (ht) send_beat(64'h7100_0000_0000_0000 | 64'(n), total == 2, rt, fl);  // R3 timestamp
    for (int k = 0; k < nbody; k++) begin
      // R2 body looks like a header of another class
      send_beat(mk_hdr(3'(c + k + 1), 1'b0, 12'(k), 16'hBEEF, 16'(n), 16'(k)),
                k == nbody - 1, rt, fl);
    end
    if (rt == 4) begin
      check(drop_count == TB_CNT_W'(drop_exp), "R7/R8 drop count", 66'(drop_count), 66'(drop_exp));
      check(bad_type_seen, "R8 sticky flag", 66'(bad_type_seen), 66'd1);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (R9 stall) actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int n;
    n = 0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(out_tvalid == 4'h0, "R11 out_tvalid", 66'(out_tvalid), 66'd0);
    check(!in_tready, "R11/R9 idle in_tready", 66'(in_tready), 66'd0);
    check(!bad_type_seen, "R11 flag", 66'(bad_type_seen), 66'd0);
    check(drop_count == '0, "R11 count", 66'(drop_count), 66'd0);
    @(posedge clk); #1;

    // sweep: modes x classes x time flag x body length (R1 R2 R3 R6 R7 R8)
    for (int m = 0; m < 2; m++) begin
      rdy_mode = m;
      for (int c = 0; c < 8; c++)
        for (int ht = 0; ht < 2; ht++)
          for (int nb = 0; nb < 4; nb++) begin
            send_pkt(3'(c), 1'(ht), nb, n);
            n++;
          end
    end
    check(drop_count == TB_CNT_W'(CNT_SAT), "R8 saturation", 66'(drop_count), 66'(CNT_SAT));

    // R9 backpressure: stall data output with full stage
    rdy_mode = 0;
    repeat (6) @(posedge clk);
    #1 rdy_mode = 2;
    repeat (3) @(posedge clk);
    #1;
    send_beat(mk_hdr(3'd0, 1'b0, 12'h5A5, 16'd16, 16'h1234, 16'h4321), 1'b0, 0, 1'b0);
    in_tdata = 64'hDEAD_0000_BEEF_0001; in_tlast = 1'b1; in_tvalid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!in_tready, "R9 stall in_tready", 66'(in_tready), 66'd0);
      check(out_tvalid == 4'b0001, "R9 only data valid", 66'(out_tvalid), 66'd1);
      check(out_tdata[63:0] == mk_hdr(3'd0, 1'b0, 12'h5A5, 16'd16, 16'h1234, 16'h4321),
            "R10 held word", 66'(out_tdata[63:0]), 66'(mk_hdr(3'd0, 1'b0, 12'h5A5, 16'd16, 16'h1234, 16'h4321)));
    end
    @(posedge clk); #1;
    rdy_mode = 0;
    send_beat(64'hDEAD_0000_BEEF_0001, 1'b1, 0, 1'b0);

    // drain and confirm nothing lost
    repeat (10) @(posedge clk);
    #1;
    for (int i = 0; i < 4; i++)
      check(exp_q[i].size() == 0, "R9 no lost beats", 66'(exp_q[i].size()), 66'd0);
    @(negedge clk);
    check(out_tvalid == 4'h0, "R7 outputs idle", 66'(out_tvalid), 66'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule